// File: doc/BRIEF.md
# Programmable Bit Pattern Matcher

This block watches an input bus, one bit lane per pin, and raises a flag when the pins satisfy a pattern the host has programmed. Each lane carries a three-bit specification built from one bit of a polarity register, one bit of a transition register and one bit of a mask register. Together they say whether the lane is ignored, must sit at a given level, must show a given edge, or must show any edge. Edges are found by comparing the present pin value with the value registered on the previous clock.

The per-lane results are combined in one of three ways: every specified lane must hit (AND), any specified lane may hit (OR), or any lane may hit and the index of the highest-numbered hitting lane is captured as a vector. A detected match sets an interrupt-pending flag. The host acknowledges it by pulsing an acknowledge input, which re-arms the matcher. Optionally the data seen at the matching edge is held on the data output until that acknowledge. A match that arrives while a previous one is still unacknowledged sets a sticky error flag, which can also drive the interrupt output. A match-only option restricts matching to cycles that a transfer strobe marks as data movement.

Top module: `pattern_matcher`

## Requirements
- R1: A one-cycle write with `cfg_we` high loads `cfg_wdata` into the register chosen by `cfg_addr`: 0 polarity, 1 transition, 2 mask, 3 control. Control bits 1:0 are the mode, bit 2 enables latch-on-match, bit 3 enables interrupt-on-error and bit 4 enables match-only. For lane i the code (polarity, transition, mask) = 100 hits when the pin is 0 and 101 hits when the pin is 1.
- R2: Code 111 hits on a 0-to-1 change and 110 on a 1-to-0 change between the previous clock's pin sample and the present pin. Code 010 hits on any change. A lane whose pin holds its value does not hit.
- R3: Codes 000, 001 and 011 make the lane ignored. An AND pattern whose lanes are all ignored never matches.
- R4: Mode 01 (AND) matches only when every specified lane hits.
- R5: Mode 10 (OR) matches when at least one specified lane hits.
- R6: Mode 11 (priority OR) matches like OR. On the match that sets `ip`, `vec` captures the index of the highest-numbered hitting lane, so lane 7 has the highest priority.
- R7: Mode 00 disables matching. `pmf` and `ip` stay 0 whatever the pins do.
- R8: `pmf` is 1 in the cycle after any clock edge at which the enabled pattern matched, regardless of match-only and of `ip`.
- R9: A match event sets `ip` at the clock edge where it is seen. `ack` high at an edge clears `ip`, and it takes priority over a match event at the same edge.
- R10: With latch-on-match set, the match event that sets `ip` captures the pins. `data_out` then holds that value until `ip` clears, after which it follows the pins again.
- R11: With latch-on-match clear, `data_out` follows the pins even while `ip` is set.
- R12: A match event while `ip` is already set sets `err`. `ack` does not clear `err`; only `err_clr` does. `irq` is high when `ip` is set, or when `err` is set and interrupt-on-error is 1.
- R13: With match-only set, a pattern match becomes a match event only in a cycle where `xfer_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | W | Monitored input lanes |
| xfer_valid | input | 1 | Marks a data-transfer cycle for match-only mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | W | Register write data |
| ack | input | 1 | Acknowledge: clears pending match |
| err_clr | input | 1 | Clears the error flag |
| data_out | output | W | Pin data, or latched data while held |
| pmf | output | 1 | Pattern-match status |
| ip | output | 1 | Interrupt pending |
| err | output | 1 | Second-match error |
| irq | output | 1 | Interrupt request |
| vec | output | $clog2(W) | Captured priority index |

## Verification
The bench builds the block with its default width of eight lanes, so the vector has three bits and every lane code, including lane 7 at the top of the priority order, can be reached directly. A table of patterns covers each lane code, each combining mode and the ignored codes. Directed sequences then cover latch hold and release, the second-match error with interrupt-on-error off and then on, acknowledge priority and match-only gating.

// File: rtl/pattern_matcher.sv
module pattern_matcher #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pins,
  input  logic          xfer_valid,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  input  logic          ack,
  input  logic          err_clr,
  output logic [W-1:0]  data_out,
  output logic          pmf,
  output logic          ip,
  output logic          err,
  output logic          irq,
  output logic [IW-1:0] vec
);

  logic [W-1:0]  pol_q, trn_q, msk_q, prev_q, hold_q;
  logic [1:0]    mode_q;
  logic          lpm_q, ioe_q, only_q;
  logic [W-1:0]  hit, care;
  logic          match_now, evt;
  logic [IW-1:0] top_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trn_q  <= '0;
      msk_q  <= '0;
      mode_q <= 2'b00;
      lpm_q  <= 1'b0;
      ioe_q  <= 1'b0;
      only_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: pol_q <= cfg_wdata;
        2'd1: trn_q <= cfg_wdata;
        2'd2: msk_q <= cfg_wdata;
        default: begin
          mode_q <= cfg_wdata[1:0];
          lpm_q  <= cfg_wdata[2];
          ioe_q  <= cfg_wdata[3];
          only_q <= cfg_wdata[4];
        end
      endcase
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_comb begin
      case ({pol_q[i], trn_q[i], msk_q[i]})
        3'b010:  hit[i] = pins[i] ^ prev_q[i];
        3'b100:  hit[i] = ~pins[i];
        3'b101:  hit[i] = pins[i];
        3'b110:  hit[i] = prev_q[i] & ~pins[i];
        3'b111:  hit[i] = ~prev_q[i] & pins[i];
        default: hit[i] = 1'b0;
      endcase
    end
    assign care[i] = pol_q[i] | (trn_q[i] & ~msk_q[i]);
  end

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < W; i++)
      if (hit[i] & care[i]) top_idx = IW'(i);
  end

  always_comb begin
    case (mode_q)
      2'b01:   match_now = (|care) & (&(hit | ~care));
      2'b10,
      2'b11:   match_now = |(hit & care);
      default: match_now = 1'b0;
    endcase
  end

  assign evt = match_now & (~only_q | xfer_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      hold_q <= '0;
      pmf    <= 1'b0;
      ip     <= 1'b0;
      err    <= 1'b0;
      vec    <= '0;
    end else begin
      prev_q <= pins;
      pmf    <= match_now;
      if (ack)
        ip <= 1'b0;
      else if (evt && !ip) begin
        ip     <= 1'b1;
        hold_q <= pins;
        vec    <= (mode_q == 2'b11) ? top_idx : '0;
      end
      if (err_clr)
        err <= 1'b0;
      else if (evt && ip)
        err <= 1'b1;
    end
  end

  assign data_out = (lpm_q && ip) ? hold_q : pins;
  assign irq      = ip | (err & ioe_q);

endmodule

// File: rtl/pattern_matcher_chk.sv
module pattern_matcher_chk #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic [1:0]    mode_q,
  input logic          lpm_q,
  input logic [W-1:0]  data_out,
  input logic          pmf,
  input logic          ip,
  input logic          err,
  input logic [IW-1:0] vec
);

  a_r9_ack_clears_ip: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ip);

  a_r12_err_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(ip));

  a_r7_disabled_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |=> !pmf);

  a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ip && $past(ip) && lpm_q && $past(lpm_q)) |-> $stable(data_out));

  a_r6_vec_on_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != $past(vec)) |-> $rose(ip));

endmodule

bind pattern_matcher pattern_matcher_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .mode_q(mode_q), .lpm_q(lpm_q),
  .data_out(data_out), .pmf(pmf), .ip(ip), .err(err), .vec(vec)
);

// File: tb/pattern_matcher_bench.sv
module pattern_matcher_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = '0;
  logic         xfer_valid = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic         ack = 1'b0;
  logic         err_clr = 1'b0;
  logic [W-1:0] data_out;
  logic         pmf, ip, err, irq;
  logic [2:0]   vec;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pattern_matcher #(.W(W)) u_pattern_matcher (
    .clk(clk), .rst_n(rst_n), .pins(pins), .xfer_valid(xfer_valid),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ack(ack), .err_clr(err_clr), .data_out(data_out), .pmf(pmf),
    .ip(ip), .err(err), .irq(irq), .vec(vec)
  );

  // {pol, trn, msk, ctrl, pins_a, pins_b, expect{3'b0,ip,1'b0,vec}}
  localparam logic [55:0] TBL [14] = '{
    {8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h10},  // R1 level one
    {8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00},  // R1 level one miss
    {8'h03, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h10},  // R4 one+zero hit
    {8'h03, 8'h00, 8'h01, 8'h01, 8'h00, 8'h03, 8'h00},  // R4 one lane misses
    {8'h08, 8'h08, 8'h08, 8'h01, 8'h00, 8'h08, 8'h10},  // R2 rising
    {8'h08, 8'h08, 8'h00, 8'h01, 8'h00, 8'h08, 8'h00},  // R2 falling wants 1->0
    {8'h08, 8'h08, 8'h00, 8'h01, 8'h08, 8'h00, 8'h10},  // R2 falling
    {8'h00, 8'h20, 8'h00, 8'h01, 8'h20, 8'h00, 8'h10},  // R2 any edge
    {8'h00, 8'h20, 8'h00, 8'h01, 8'h20, 8'h20, 8'h00},  // R2 no change
    {8'h42, 8'h00, 8'h42, 8'h02, 8'h00, 8'h40, 8'h10},  // R5 OR hit
    {8'h42, 8'h00, 8'h42, 8'h02, 8'hFF, 8'h00, 8'h00},  // R5 OR miss
    {8'hFF, 8'h00, 8'hFF, 8'h03, 8'h00, 8'h24, 8'h15},  // R6 vec 5
    {8'h01, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00},  // R7 disabled
    {8'h00, 8'h00, 8'hFF, 8'h01, 8'h00, 8'hFF, 8'h00}   // R3 codes 001
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [7:0] p, t, m, c, a);
    ack = 1'b1; err_clr = 1'b1; pins = a;
    wr(2'd0, p); wr(2'd1, t); wr(2'd2, m); wr(2'd3, c);
    tick();
    ack = 1'b0; err_clr = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R9 reset ip", ip, 0);
    chk("R12 reset err", err, 0);
    chk("R8 reset pmf", pmf, 0);
    chk("R12 reset irq", irq, 0);
    chk("R11 reset data", data_out, pins);

    for (int k = 0; k < 14; k++) begin
      logic [55:0] e;
      e = TBL[k];
      setup(e[55:48], e[47:40], e[39:32], e[31:24], e[23:16]);
      pins = e[15:8];
      tick();
      chk($sformatf("R4/R5 vector %0d ip", k), ip, e[4]);
      chk($sformatf("R8 vector %0d pmf", k), pmf, e[4]);
      if (e[4]) chk($sformatf("R6 vector %0d vec", k), vec, e[2:0]);
    end

    // Latch-on-match and error
    setup(8'h01, 8'h00, 8'h01, 8'h05, 8'h00);
    pins = 8'h81; tick();
    chk("R10 latch set ip", ip, 1);
    chk("R10 latch value", data_out, 8'h81);
    pins = 8'h80; tick();
    chk("R10 latch holds", data_out, 8'h81);
    chk("R12 no err yet", err, 0);
    pins = 8'h81; tick();
    chk("R12 second match err", err, 1);
    ack = 1'b1; pins = 8'h00; tick(); ack = 1'b0;
    chk("R9 ack clears ip", ip, 0);
    chk("R12 err survives ack", err, 1);
    chk("R12 irq off without ioe", irq, 0);
    chk("R10 released", data_out, 8'h00);
    wr(2'd3, 8'h0D);
    chk("R12 irq with ioe", irq, 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R12 err_clr", err, 0);
    chk("R12 irq after clear", irq, 0);

    // Latch off, ack priority
    setup(8'h01, 8'h00, 8'h01, 8'h01, 8'h00);
    pins = 8'h81; tick();
    chk("R11 ip set", ip, 1);
    pins = 8'h03; tick();
    chk("R11 data follows", data_out, 8'h03);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R9 ack beats match", ip, 0);

    // Match-only
    setup(8'h01, 8'h00, 8'h01, 8'h11, 8'h00);
    pins = 8'h01; tick();
    chk("R13 gated ip", ip, 0);
    chk("R8 pmf despite gate", pmf, 1);
    xfer_valid = 1'b1; tick(); xfer_valid = 1'b0;
    chk("R13 xfer ip", ip, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule